// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. It watches the receive line with a tick that runs at sixteen times the bit rate. It confirms a start bit at its centre, then samples every later bit once, at its mid-point. It rebuilds a character of five to eight data bits, least significant bit first. It optionally reads a parity bit and checks it against the framing selected by the line-control inputs. The line-control inputs use the same encoding that a matching transmitter uses.

When the stop bit has been sampled, the block presents the character together with three flags: a parity error flag, a framing error flag and a line-break flag. A one-clock valid strobe marks the update. The outputs then hold until the next character completes. After a break, the receiver waits for the line to return to idle before it looks for another start bit.

Top module: `serial_frame_rx`

## Requirements
- R1: On a tick in which the idle line is low, a frame begins; that tick counts as tick 0. The line is checked again at tick 8. If it is high there, the event is treated as noise and no character is produced.
- R2: Each data, parity and stop bit is sampled once, 16 ticks after the previous sample. Data bits arrive least significant bit first.
- R3: `wlen_sel` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Output bits above the word length read 0.
- R4: With `par_on`=0 no parity bit is expected. The stop bit is sampled one bit time after the last data bit, and `err_parity` reads 0.
- R5: With `par_on`=1 and `par_fixed`=0, `par_even`=0 requires an odd count of ones over the data bits plus the parity bit, and `par_even`=1 requires an even count. A mismatch sets `err_parity`.
- R6: With `par_on`=1 and `par_fixed`=1, `par_even`=0 requires the parity bit to be 1 and `par_even`=1 requires it to be 0. A mismatch sets `err_parity`.
- R7: A stop bit sampled as 0 sets `err_frame`. Only the first stop bit is examined.
- R8: `brk_det` is set when every data bit, the parity bit (if present) and the stop bit are all 0. A break also sets `err_frame`. After a break, no new frame starts until the line has been high on a tick.
- R9: `rx_valid` is high for exactly one clock, in the clock in which `rx_data` and the three flags take their new values. Those outputs do not change at any other time.
- R10: During and right after reset all outputs read 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line, idle high, already synchronous to clk |
| baud_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| wlen_sel | input | 2 | Data bit count select (5 to 8) |
| par_on | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Parity kind: odd/mark when 0, even/space when 1 |
| par_fixed | input | 1 | Parity bit is a fixed level instead of a computed one |
| rx_data | output | 8 | Received character, zero-extended |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity bit did not match the selected rule |
| brk_det | output | 1 | All-zero frame seen |
| rx_valid | output | 1 | One-clock strobe on each completed character |

## Verification
The bench builds the block with the default oversampling ratio of 16, so the start check falls on tick 8 and each later sample lies 16 ticks on. The tick fires every fourth clock. This keeps a whole 8-bit frame with parity under a thousand clocks, so all four word lengths, all four parity rules with good and corrupted parity bits, a bad stop bit, noise pulses and two breaks fit in one short run. A behavioural model predicts the exact tick at which each character completes and compares the outputs on every clock.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned SRX_DW = 8;
  localparam int unsigned SRX_IW = $clog2(SRX_DW);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } srx_state_t;

  // Index of the last data bit for a word-length select (5..8 bits).
  function automatic logic [SRX_IW-1:0] last_bit_idx(input logic [1:0] sel);
    return SRX_IW'(4) + SRX_IW'(sel);
  endfunction

  // Parity bit the line must carry for the given data and rule.
  function automatic logic want_parity(input logic [SRX_DW-1:0] d,
                                       input logic even_kind,
                                       input logic fixed_level);
    if (fixed_level) return ~even_kind;
    return even_kind ? (^d) : ~(^d);
  endfunction

endpackage

// File: rtl/srx_fsm.sv
module srx_fsm
  import srx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        wlen_sel,
  input  logic              par_on,
  input  logic              brk_now,
  output logic              clear_ev,
  output logic              data_ev,
  output logic              par_ev,
  output logic              stop_ev,
  output logic [SRX_IW-1:0] bit_idx
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS / 2 - 1);

  srx_state_t       state, nstate;
  logic [CNT_W-1:0] cnt;
  logic             tick_end, mid_hit, glitch_ev, busy;

  assign tick_end  = tick && (cnt == CNT_LAST);
  assign mid_hit   = tick && (cnt == MID_LAST);
  assign clear_ev  = (state == ST_IDLE) && tick && !rx;
  assign glitch_ev = (state == ST_START) && mid_hit && rx;
  assign data_ev   = (state == ST_DATA) && tick_end;
  assign par_ev    = (state == ST_PAR) && tick_end;
  assign stop_ev   = (state == ST_STOP) && tick_end;
  assign busy      = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PAR)   || (state == ST_STOP);

  always_comb begin
    nstate = state;
    unique case (state)
      ST_IDLE:  if (clear_ev) nstate = ST_START;
      ST_START: if (mid_hit) nstate = glitch_ev ? ST_IDLE : ST_DATA;
      ST_DATA:  if (data_ev && bit_idx == last_bit_idx(wlen_sel))
                  nstate = par_on ? ST_PAR : ST_STOP;
      ST_PAR:   if (par_ev) nstate = ST_STOP;
      ST_STOP:  if (stop_ev) nstate = brk_now ? ST_HOLD : ST_IDLE;
      ST_HOLD:  if (tick && rx) nstate = ST_IDLE;
      default:  nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      state <= nstate;
      if (state != nstate)     cnt <= '0;
      else if (tick && busy)   cnt <= tick_end ? '0 : cnt + 1'b1;
      if (clear_ev)            bit_idx <= '0;
      else if (data_ev)        bit_idx <= bit_idx + 1'b1;
    end
  end

  // R2
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clear_ev, data_ev, par_ev, stop_ev}));

endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic              clear_ev,
  input  logic              data_ev,
  input  logic              par_ev,
  input  logic [SRX_IW-1:0] bit_idx,
  output logic [SRX_DW-1:0] data_q,
  output logic              par_q,
  output logic              saw_one
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      par_q   <= 1'b0;
      saw_one <= 1'b0;
    end else if (clear_ev) begin
      data_q  <= '0;
      par_q   <= 1'b0;
      saw_one <= 1'b0;
    end else if (data_ev) begin
      data_q[bit_idx] <= rx;
      saw_one         <= saw_one | rx;
    end else if (par_ev) begin
      par_q   <= rx;
      saw_one <= saw_one | rx;
    end
  end
endmodule

// File: rtl/srx_check.sv
module srx_check
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic              stop_ev,
  input  logic              brk_now,
  input  logic [SRX_DW-1:0] data_q,
  input  logic              par_q,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              par_fixed,
  output logic [SRX_DW-1:0] rx_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              brk_det,
  output logic              rx_valid
);
  logic par_bad;
  assign par_bad = par_on && (par_q != want_parity(data_q, par_even, par_fixed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      brk_det    <= 1'b0;
      rx_valid   <= 1'b0;
    end else begin
      rx_valid <= stop_ev;
      if (stop_ev) begin
        rx_data    <= data_q;
        err_frame  <= !rx;
        err_parity <= par_bad;
        brk_det    <= brk_now;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(err_frame) &&
                   $stable(err_parity) && $stable(brk_det)));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import srx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              baud_tick,
  input  logic [1:0]        wlen_sel,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              par_fixed,
  output logic [SRX_DW-1:0] rx_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              brk_det,
  output logic              rx_valid
);
  logic              clear_ev, data_ev, par_ev, stop_ev;
  logic [SRX_IW-1:0] bit_idx;
  logic [SRX_DW-1:0] data_q;
  logic              par_q, saw_one, brk_now;

  // Break: nothing but zeros, including the stop bit now on the line.
  assign brk_now = !saw_one && !rx_line;

  srx_fsm #(.OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_line),
    .wlen_sel(wlen_sel), .par_on(par_on), .brk_now(brk_now),
    .clear_ev(clear_ev), .data_ev(data_ev), .par_ev(par_ev),
    .stop_ev(stop_ev), .bit_idx(bit_idx)
  );

  srx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .rx(rx_line), .clear_ev(clear_ev),
    .data_ev(data_ev), .par_ev(par_ev), .bit_idx(bit_idx),
    .data_q(data_q), .par_q(par_q), .saw_one(saw_one)
  );

  srx_check u_check (
    .clk(clk), .rst_n(rst_n), .rx(rx_line), .stop_ev(stop_ev),
    .brk_now(brk_now), .data_q(data_q), .par_q(par_q),
    .par_on(par_on), .par_even(par_even), .par_fixed(par_fixed),
    .rx_data(rx_data), .err_frame(err_frame), .err_parity(err_parity),
    .brk_det(brk_det), .rx_valid(rx_valid)
  );

  // R8
  brk_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> err_frame);

  // R4
  nopar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_on) |-> !err_parity);

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] wlen_sel = 2'b11;
  logic       par_on = 1'b0, par_even = 1'b0, par_fixed = 1'b0;
  logic [7:0] rx_data;
  logic       err_frame, err_parity, brk_det, rx_valid;

  serial_frame_rx i_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .wlen_sel(wlen_sel), .par_on(par_on), .par_even(par_even),
    .par_fixed(par_fixed), .rx_data(rx_data), .err_frame(err_frame),
    .err_parity(err_parity), .brk_det(brk_det), .rx_valid(rx_valid)
  );

  always #4 clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    baud_tick = (div == 0);
  end

  int tcnt = 0;
  bit ltp = 1'b0;
  always @(posedge clk) begin
    ltp <= baud_tick;
    if (baud_tick && rst_n) tcnt <= tcnt + 1;
  end

  int checks = 0, fails = 0, nvalid = 0;
  bit live = 1'b0, pend = 1'b0, done = 1'b0;
  int exp_k = 0;
  logic [7:0] e_data, h_data = 8'h00;
  logic e_pe, e_fe, e_bk;
  logic h_pe = 1'b0, h_fe = 1'b0, h_bk = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference model compared every clock
  always @(negedge clk) begin
    if (live) begin
      if (rx_valid === 1'b1) nvalid++;
      if (pend && ltp && tcnt == exp_k + 1) begin
        chk("R9 valid strobe", rx_valid, 1);
        chk("R3 data", rx_data, e_data);
        chk("R5 parity flag", err_parity, e_pe);
        chk("R7 frame flag", err_frame, e_fe);
        chk("R8 break flag", brk_det, e_bk);
        h_data = e_data; h_pe = e_pe; h_fe = e_fe; h_bk = e_bk;
        pend = 1'b0;
      end else begin
        chk("R9 no strobe", rx_valid, 0);
        chk("R9 data held", rx_data, h_data);
        chk("R9 flags held", {err_parity, err_frame, brk_det}, {h_pe, h_fe, h_bk});
      end
    end
  end

  task automatic wait_t(input int t);
    while (tcnt < t) @(negedge clk);
  endtask

  task automatic tick_edge();
    @(negedge clk);
    while (!ltp) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pon,
                            input bit pev, input bit pfx, input bit bad_par,
                            input bit bad_stop, input bit brk_line);
    logic [7:0] dm;
    logic       pgood, pbit;
    logic [9:0] bits;
    int         n, k0, nv;
    wlen_sel = 2'(nb - 5);
    par_on = pon; par_even = pev; par_fixed = pfx;
    dm = d & 8'((1 << nb) - 1);
    if (brk_line) dm = 8'h00;
    if (pfx) pgood = !pev;
    else if (pev) pgood = ($countones(dm) % 2) == 1;
    else pgood = ($countones(dm) % 2) == 0;
    pbit = brk_line ? 1'b0 : (pgood ^ bad_par);
    bits = '0;
    for (int i = 0; i < nb; i++) bits[i] = dm[i];
    if (pon) bits[nb] = pbit;
    n = nb + (pon ? 1 : 0);
    tick_edge();
    k0 = tcnt;
    rx_line = 1'b0;
    e_data = dm;
    e_pe = pon && (pbit !== pgood);
    e_fe = bad_stop || brk_line;
    e_bk = brk_line || (dm == 0 && (!pon || !pbit) && bad_stop);
    exp_k = k0 + 24 + 16 * n;
    pend = 1'b1;
    for (int j = 0; j < n; j++) begin
      wait_t(k0 + 16 * (j + 1));
      rx_line = bits[j];
    end
    wait_t(k0 + 16 * (n + 1));
    if (brk_line) begin
      rx_line = 1'b0;
      wait_t(k0 + 16 * (n + 1) + 20);
      nv = nvalid;
      wait_t(k0 + 16 * (n + 1) + 48);
      chk("R8 no start while line held low", nvalid, nv);
      rx_line = 1'b1;
      wait_t(k0 + 16 * (n + 1) + 60);
    end else if (bad_stop) begin
      rx_line = 1'b0;
      wait_t(k0 + 16 * (n + 1) + 9);
      rx_line = 1'b1;
      wait_t(k0 + 16 * (n + 2) + 4);
    end else begin
      rx_line = 1'b1;
      wait_t(k0 + 16 * (n + 2) + 4);
    end
    chk("R2 character completed on time", pend, 0);
  endtask

  task automatic glitch(input int len);
    int k0, nv;
    tick_edge();
    k0 = tcnt;
    nv = nvalid;
    rx_line = 1'b0;
    wait_t(k0 + len);
    rx_line = 1'b1;
    wait_t(k0 + 40);
    chk("R1 noise pulse gives no character", nvalid, nv);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 reset data", rx_data, 0);
    chk("R10 reset flags", {rx_valid, err_frame, err_parity, brk_det}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {rx_valid, rx_data}, 0);
    live = 1'b1;
    repeat (20) @(negedge clk);
    // R3 R4: 8 bits and 5 bits, no parity
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, 0);
    send_frame(8'hF3, 5, 0, 0, 0, 0, 0, 0);
    send_frame(8'h6B, 6, 0, 0, 0, 0, 0, 0);
    // R5: odd and even, good and bad
    send_frame(8'h2D, 6, 1, 0, 0, 0, 0, 0);
    send_frame(8'h55, 7, 1, 1, 0, 0, 0, 0);
    send_frame(8'h55, 7, 1, 1, 0, 1, 0, 0);
    send_frame(8'hC1, 8, 1, 0, 0, 1, 0, 0);
    send_frame(8'h00, 8, 1, 0, 0, 0, 0, 0);
    // R6: fixed mark and fixed space
    send_frame(8'h3A, 8, 1, 0, 1, 0, 0, 0);
    send_frame(8'h3A, 8, 1, 0, 1, 1, 0, 0);
    send_frame(8'h17, 5, 1, 1, 1, 0, 0, 0);
    send_frame(8'h17, 5, 1, 1, 1, 1, 0, 0);
    // R7: low stop bit
    send_frame(8'h3C, 8, 0, 0, 0, 0, 1, 0);
    // R1: noise pulses of 5 and 8 ticks, then a normal frame
    glitch(5);
    glitch(8);
    send_frame(8'h81, 8, 1, 1, 0, 0, 0, 0);
    // R8: breaks, each followed by a normal frame
    send_frame(8'h00, 8, 0, 0, 0, 0, 0, 1);
    send_frame(8'h5E, 7, 0, 0, 0, 0, 0, 0);
    send_frame(8'h00, 6, 1, 1, 0, 0, 0, 1);
    send_frame(8'h9C, 8, 1, 0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule